// File: doc/BRIEF.md
# Power-Up NAND Chain Connectivity Test

This block provides board-level connectivity testing for a small monitoring device. Right after power-on reset it samples a strap input once. If the strap is high, the device enters a test mode. In that mode the six digital inputs (serial data, serial clock and a four-bit identification bus) feed a chain of two-input NAND gates. The end of the chain then drives the multifunction output pin in place of its usual reset/interrupt signal.

Test equipment holds every input low. It then raises the inputs one at a time and leaves each one high, starting with the input nearest the chain output. Each step flips the output pin, which shows that every input is connected. The gate delay is modelled as a fixed number of clock cycles between a change at the inputs and its effect at the pin.

When the strap is sampled low, the pin simply carries the normal reset/interrupt signal. The captured mode stays fixed until the next power-on reset.

Top module: `ntree_top`

## Requirements
- R1: While `porN` is low, `pinOut` equals `normalPin`.
- R2: On the first rising clock edge with `porN` high, the mode is captured from `modePin`: 1 selects test mode, 0 selects normal mode.
- R3: In normal mode, `pinOut` equals `normalPin` in the same cycle, whatever the tree inputs do.
- R4: Once captured, the mode ignores later changes on `modePin` in either direction until `porN` goes low again.
- R5: In test mode, `pinOut` does not depend on `normalPin`.
- R6: The chain inputs are ordered by index, with index 0 nearest the output: 0=`sdaIn`, 1=`sclIn`, 2..5=`vidIn[0]`..`vidIn[3]`. Stage 0 is NAND(1, input 5). Stage k is NAND(input 5-k, stage k-1). The last stage is the tree output.
- R7: Start with all inputs low, where the output is 1. Raising inputs 0 through 5 one after another, each left high, inverts the test-mode output at every step.
- R8: A tree-input change applied between clock edges reaches `pinOut` after exactly `DELAY_CYC` rising edges (default 4), and not after fewer.
- R9: A new power-on reset re-captures the mode from `modePin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Active-low power-on reset, asynchronous assert |
| modePin | input | 1 | Strap sampled once after reset; 1 selects test mode |
| sdaIn | input | 1 | Serial data input, tree input 0 |
| sclIn | input | 1 | Serial clock input, tree input 1 |
| vidIn | input | NUM_VID (4) | Identification inputs, tree inputs 2 and up |
| normalPin | input | 1 | Normal reset/interrupt level for the shared pin |
| pinOut | output | 1 | Level driven onto the multifunction pin |

## Verification
The bench aims at the input ordering. A chain wired in the reverse direction, or with a leaf not tied high, fails both the walking-one sequence and the fixed patterns that hold a single far input high. It moves the strap after capture: a latch that keeps tracking the strap would flip the pin between test output and normal level. It also counts the delay edge by edge, so a pipeline one stage short or long shows the new value one sample early or late. Finally, it drives `normalPin` to the opposite of the expected tree value and toggles the tree inputs in normal mode, which exposes a mux that leaks either source.

// File: rtl/ntree_pkg.sv
package ntree_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic testSel;  // 1: pin carries tree output
    logic pipeClr;  // 1: mode not yet captured, hold pipeline cleared
  } ctrlStrobes_t;
endpackage

// File: rtl/ntree_mode_ctrl.sv
module ntree_mode_ctrl
  import ntree_pkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  logic         modePin,
  output ctrlStrobes_t strb
);
  logic captured;
  logic modeQ;

  // one-shot capture on first edge after reset release
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      captured <= 1'b0;
      modeQ    <= 1'b0;
    end else if (!captured) begin
      captured <= 1'b1;
      modeQ    <= modePin;
    end
  end

  always_comb begin
    strb.testSel = modeQ;
    strb.pipeClr = ~captured;
  end
endmodule

// File: rtl/ntree_chain_dpath.sv
module ntree_chain_dpath
  import ntree_pkg::*;
#(
  parameter int NUM_IN    = 6,
  parameter int DELAY_CYC = 4
) (
  input  logic              clk,
  input  logic              porN,
  input  ctrlStrobes_t      strb,
  input  logic [NUM_IN-1:0] treeIn,    // index 0 nearest the output
  input  logic              normalPin,
  output logic              pinOut
);
  localparam int LAST = NUM_IN - 1;

  logic [NUM_IN-1:0]    stage;
  logic [DELAY_CYC-1:0] dly;

  // linear chain: farthest input feeds stage 0 with its other leg tied high
  assign stage[0] = ~(1'b1 & treeIn[LAST]);
  for (genvar k = 1; k < NUM_IN; k++) begin : g_chain
    assign stage[k] = ~(treeIn[LAST-k] & stage[k-1]);
  end

  // propagation delay model
  if (DELAY_CYC == 1) begin : g_dly1
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)             dly <= '0;
      else if (strb.pipeClr) dly <= '0;
      else                   dly <= stage[LAST];
    end
  end else begin : g_dlyN
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)             dly <= '0;
      else if (strb.pipeClr) dly <= '0;
      else                   dly <= {dly[DELAY_CYC-2:0], stage[LAST]};
    end
  end

  assign pinOut = strb.testSel ? dly[DELAY_CYC-1] : normalPin;
endmodule

// File: rtl/ntree_top.sv
module ntree_top
  import ntree_pkg::*;
#(
  parameter int NUM_VID   = 4,
  parameter int DELAY_CYC = 4
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               modePin,
  input  logic               sdaIn,
  input  logic               sclIn,
  input  logic [NUM_VID-1:0] vidIn,
  input  logic               normalPin,
  output logic               pinOut
);
  localparam int NUM_IN = NUM_VID + 2;

  ctrlStrobes_t      strb;
  logic [NUM_IN-1:0] treeIn;

  assign treeIn = {vidIn, sclIn, sdaIn};

  ntree_mode_ctrl uCtrl (
    .clk     (clk),
    .porN    (porN),
    .modePin (modePin),
    .strb    (strb)
  );

  ntree_chain_dpath #(
    .NUM_IN    (NUM_IN),
    .DELAY_CYC (DELAY_CYC)
  ) uDpath (
    .clk       (clk),
    .porN      (porN),
    .strb      (strb),
    .treeIn    (treeIn),
    .normalPin (normalPin),
    .pinOut    (pinOut)
  );
endmodule

// File: rtl/ntree_chk.sv
module ntree_chk (
  input logic clk,
  input logic porN,
  input logic modePin,
  input logic normalPin,
  input logic pinOut,
  input logic testSel,
  input logic pipeClr
);
  p_reset_passthru_r1: assert property (@(posedge clk)
    !porN |-> (pinOut == normalPin));

  p_capture_r2: assert property (@(posedge clk) disable iff (!porN)
    pipeClr |=> (testSel == $past(modePin)) && !pipeClr);

  p_normal_passthru_r3: assert property (@(posedge clk) disable iff (!porN)
    (!pipeClr && !testSel) |-> (pinOut == normalPin));

  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!porN)
    !pipeClr |=> !pipeClr && $stable(testSel));
endmodule

bind ntree_top ntree_chk uChk (
  .clk       (clk),
  .porN      (porN),
  .modePin   (modePin),
  .normalPin (normalPin),
  .pinOut    (pinOut),
  .testSel   (strb.testSel),
  .pipeClr   (strb.pipeClr)
);

// File: tb/sim_ntree_top.sv
`timescale 1ns/1ps
module sim_ntree_top;
  localparam int DLY = 4;

  logic clk = 1'b0;
  logic porN, modePin, sdaIn, sclIn, normalPin;
  logic [3:0] vidIn;
  wire pinOut;

  int errCnt = 0;
  int chkCnt = 0;

  always #2 clk = ~clk;

  ntree_top #(.NUM_VID(4), .DELAY_CYC(DLY)) u0 (
    .clk(clk), .porN(porN), .modePin(modePin), .sdaIn(sdaIn),
    .sclIn(sclIn), .vidIn(vidIn), .normalPin(normalPin), .pinOut(pinOut)
  );

  // {tree inputs idx5..idx0, expected output}
  localparam logic [6:0] VEC [11] = '{
    {6'b000000, 1'b1}, {6'b111111, 1'b1}, {6'b000001, 1'b0},
    {6'b100000, 1'b1}, {6'b000011, 1'b1}, {6'b011111, 1'b0},
    {6'b101010, 1'b1}, {6'b010101, 1'b0}, {6'b111110, 1'b1},
    {6'b111101, 1'b0}, {6'b001111, 1'b1}
  };

  task automatic chk(input logic act, input logic exp, input string req);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic setTree(input logic [5:0] v);
    {vidIn, sclIn, sdaIn} = v;
  endtask

  task automatic waitDly();
    repeat (DLY) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic powerUp(input logic strap);
    @(negedge clk);
    porN = 1'b0;
    modePin = strap;
    repeat (2) @(negedge clk);
    porN = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    logic expW;
    porN = 1'b0; modePin = 1'b1; normalPin = 1'b0; setTree(6'b0);
    #1;
    chk(pinOut, 1'b0, "R1 reset low");
    normalPin = 1'b1; #1;
    chk(pinOut, 1'b1, "R1 reset high");

    // test mode (R2), strap released afterwards (R4)
    powerUp(1'b1);
    modePin = 1'b0;
    for (int i = 0; i < 11; i++) begin
      setTree(VEC[i][6:1]);
      normalPin = ~VEC[i][0];   // R5: opposite level must not leak
      waitDly();
      chk(pinOut, VEC[i][0], $sformatf("R6 R5 R2 R4 vec %0d", i));
    end

    // walking one R7
    setTree(6'b0);
    waitDly();
    expW = 1'b1;
    chk(pinOut, expW, "R7 all low");
    for (int k = 0; k < 6; k++) begin
      setTree(6'((1 << (k + 1)) - 1));
      waitDly();
      expW = ~expW;
      chk(pinOut, expW, $sformatf("R7 step %0d", k));
    end

    // delay R8: 111111 (1) -> 111101 (0)
    setTree(6'b111101);
    repeat (DLY - 1) @(posedge clk);
    @(negedge clk);
    chk(pinOut, 1'b1, "R8 too early");
    @(posedge clk);
    @(negedge clk);
    chk(pinOut, 1'b0, "R8 on time");

    // normal mode R3 R9, strap raised afterwards R4
    powerUp(1'b0);
    modePin = 1'b1;
    setTree(6'b000001);
    normalPin = 1'b1; #1;
    chk(pinOut, 1'b1, "R3 R9 normal high");
    normalPin = 1'b0; #1;
    chk(pinOut, 1'b0, "R3 normal low");
    setTree(6'b000000);
    waitDly();
    chk(pinOut, 1'b0, "R3 R4 tree ignored");
    normalPin = 1'b1; #1;
    chk(pinOut, 1'b1, "R4 strap ignored");

    // re-enter test mode R9
    powerUp(1'b1);
    setTree(6'b010101);
    normalPin = 1'b1;
    waitDly();
    chk(pinOut, 1'b0, "R9 test again");

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule